// File: doc/BRIEF.md
# Digital Clock Recovery Divider

This block rebuilds a bit-rate clock for a bipolar line decoder. Its only timing source is a local reference clock that runs at a fixed multiple of the nominal data rate, by default eight times that rate: 16.384 MHz for a 2.048 Mbit/s line, or 12.352 MHz for a 1.544 Mbit/s line. The positive and negative receive rails are ORed into one mark-activity signal. That signal passes through a synchroniser in the reference domain, and its rising edges are detected there.

A modulo-DIV phase counter makes the recovered clock. Its top bit is the recovered clock. Each detected mark loads the counter with a fixed phase, chosen so that the recovered clock's rising edge falls half a bit period after the mark was first sampled, which is close to the centre of the bit. When no marks arrive, the counter free-runs at the reference rate divided by DIV. With a jitter-free input, the phase error therefore ramps as a sawtooth over a range of one reference step.

A mode input picks the decoder clock. When the input is high, the decoder uses the internally recovered clock. When it is low, an external clock input is passed through instead, and the ORed rail activity is driven out so that external circuitry can recover the clock.

Top module: `cdr_clock_recovery`

## Requirements
- R1: While rst_n is low, dec_clk is 0 with mode_int high. After rst_n is released, the phase count starts from 0. It advances by one on each reference edge, and dec_clk is 1 exactly when the count is at least DIV/2.
- R2: A mark on rx_pos alone, on rx_neg alone, or on both rails together re-phases the recovered clock in the same way.
- R3: With no new mark, the recovered clock free-runs with period DIV reference cycles. It is low for DIV/2 cycles, then high for DIV/2 cycles.
- R4: Let edge k be the first reference edge that samples a rising edge of (rx_pos OR rx_neg). After edge k+n, for n >= SYNC_STAGES and until the next re-phase takes effect, the recovered clock is 1 exactly when (n mod DIV) >= DIV/2. Its rising edge therefore follows edge k+DIV/2.
- R5: Only a rising edge of rail activity re-phases the clock. Activity that stays high for many cycles re-phases the clock once, and the clock then free-runs.
- R6: With mode_int = 1, dec_clk is the internally recovered clock.
- R7: With mode_int = 0, dec_clk equals ext_clk_in, and cdr_out equals rx_pos OR rx_neg.
- R8: With mode_int = 1, cdr_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock at DIV times the data rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pos | input | 1 | Positive receive rail |
| rx_neg | input | 1 | Negative receive rail |
| mode_int | input | 1 | 1 selects the internally recovered clock, 0 selects the external clock |
| ext_clk_in | input | 1 | Externally recovered clock |
| dec_clk | output | 1 | Decoder clock |
| cdr_out | output | 1 | ORed rail activity, for external recovery (0 in internal mode) |

## Verification
A mark first sampled at edge k loads the counter at edge k+2: two edges pass through the synchroniser and the third edge loads the count. The recovered clock rises at edge k+4. The bench keeps a reference model: an edge index, plus a pending re-phase that takes effect two edges after its sampling edge. From that model it computes the expected level as ((edge - anchor) mod 8) >= 4. It compares this with dec_clk at each falling edge, when all registers have settled. The mode mux and cdr_out are combinational, so the bench compares them in the same half cycle as the inputs that were driven.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
   localparam int unsigned CDR_DIV_DFLT  = 8;
   localparam int unsigned CDR_SYNC_DFLT = 2;

   function automatic bit cdr_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/cdr_mark_sync.sv
module cdr_mark_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic act_in,
   output logic mark_evt
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk_ref or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= act_in;
         end
      end else begin : g_chain
         always_ff @(posedge clk_ref or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[STAGES-2:0], act_in};
         end
      end
   endgenerate

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[STAGES-1];
   end

   assign mark_evt = sync_q[STAGES-1] & ~last_q;

   // R5
   single_pulse_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      mark_evt |=> !mark_evt);
endmodule

// File: rtl/cdr_phase_counter.sv
module cdr_phase_counter #(
   parameter int unsigned DIV  = 8,
   parameter int unsigned LOAD = 2
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic mark_evt,
   output logic rec_clk
);
   localparam int unsigned W = $clog2(DIV);
   localparam logic [W-1:0] LOAD_V = W'(LOAD);
   localparam logic [W-1:0] ONE_V  = W'(1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (mark_evt) cnt_q <= LOAD_V;
      else               cnt_q <= cnt_q + ONE_V;
   end

   assign rec_clk = cnt_q[W-1];

   // R4
   load_phase_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      mark_evt |=> (cnt_q == LOAD_V));
   // R4
   mark_low_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      mark_evt |=> !rec_clk);
   // R3
   free_run_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !mark_evt |=> (cnt_q == $past(cnt_q) + ONE_V));
endmodule

// File: rtl/cdr_clock_select.sv
module cdr_clock_select (
   input  logic mode_int,
   input  logic rec_clk,
   input  logic ext_clk_in,
   input  logic act_in,
   output logic dec_clk,
   output logic cdr_out
);
   assign dec_clk = mode_int ? rec_clk : ext_clk_in;
   assign cdr_out = ~mode_int & act_in;
endmodule

// File: rtl/cdr_clock_recovery.sv
module cdr_clock_recovery #(
   parameter int unsigned DIV         = cdr_pkg::CDR_DIV_DFLT,
   parameter int unsigned SYNC_STAGES = cdr_pkg::CDR_SYNC_DFLT
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic rx_pos,
   input  logic rx_neg,
   input  logic mode_int,
   input  logic ext_clk_in,
   output logic dec_clk,
   output logic cdr_out
);
   localparam int unsigned HALF = DIV / 2;
   localparam int unsigned LOAD = SYNC_STAGES % DIV;

   if (!cdr_pkg::cdr_is_pow2(DIV) || DIV < 4) begin : g_bad_div
      $error("DIV must be a power of two of at least 4");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES >= HALF) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2 and below DIV/2");
   end

   logic act;
   logic mark_evt;
   logic rec_clk;

   assign act = rx_pos | rx_neg;

   cdr_mark_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_ref (clk_ref),
      .rst_n   (rst_n),
      .act_in  (act),
      .mark_evt(mark_evt)
   );

   cdr_phase_counter #(.DIV(DIV), .LOAD(LOAD)) u_cnt (
      .clk_ref (clk_ref),
      .rst_n   (rst_n),
      .mark_evt(mark_evt),
      .rec_clk (rec_clk)
   );

   cdr_clock_select u_sel (
      .mode_int  (mode_int),
      .rec_clk   (rec_clk),
      .ext_clk_in(ext_clk_in),
      .act_in    (act),
      .dec_clk   (dec_clk),
      .cdr_out   (cdr_out)
   );

   // R8
   cdr_quiet_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      mode_int |-> !cdr_out);
endmodule

// File: tb/test_cdr_clock_recovery.sv
module test_cdr_clock_recovery;
   localparam int PERIOD = 10;
   localparam int DIV    = 8;
   localparam int LAT    = 2;

   logic clk_ref = 1'b0;
   logic rst_n = 1'b0;
   logic rx_pos = 1'b0, rx_neg = 1'b0, mode_int = 1'b1, ext_clk_in = 1'b0;
   logic dec_clk, cdr_out;

   int n_chk = 0, n_fail = 0;
   string cur_tag = "R1";
   bit done = 1'b0;

   // bench model state
   int edge_i = 0, anchor = 0, pend = 0;
   bit pend_v = 1'b0, or_prev = 1'b0;

   cdr_clock_recovery i_cdr_clock_recovery (
      .clk_ref(clk_ref), .rst_n(rst_n), .rx_pos(rx_pos), .rx_neg(rx_neg),
      .mode_int(mode_int), .ext_clk_in(ext_clk_in),
      .dec_clk(dec_clk), .cdr_out(cdr_out)
   );

   always #(PERIOD/2) clk_ref = ~clk_ref;

   always @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         edge_i = 0; anchor = 0; pend_v = 1'b0; or_prev = 1'b0;
      end else begin
         bit orv;
         edge_i++;
         orv = rx_pos | rx_neg;
         if (pend_v && edge_i == pend + LAT) begin
            anchor = pend; pend_v = 1'b0;
         end
         if (orv && !or_prev) begin
            pend = edge_i; pend_v = 1'b1;
         end
         or_prev = orv;
      end
   end

   function automatic logic exp_level(input int e, input int a);
      return (((e - a) % DIV) >= DIV / 2) ? 1'b1 : 1'b0;
   endfunction

   task automatic check(input string tag, input logic act, input logic expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b (edge %0d)", tag, act, expv, edge_i);
      end
   endtask

   task automatic tick();
      @(negedge clk_ref);
      if (!rst_n) begin
         check("R1", dec_clk, 1'b0);
      end else if (mode_int) begin
         check(cur_tag, dec_clk, exp_level(edge_i, anchor));
         check("R8", cdr_out, 1'b0);
      end else begin
         check("R7", dec_clk, ext_clk_in);
         check("R7", cdr_out, rx_pos | rx_neg);
      end
   endtask

   task automatic idle(input int n);
      rx_pos = 1'b0; rx_neg = 1'b0;
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic mark(input logic p, input logic q, input int hold);
      rx_pos = p; rx_neg = q;
      for (int i = 0; i < hold; i++) tick();
      rx_pos = 1'b0; rx_neg = 1'b0;
   endtask

   initial begin
      int seed;
      seed = 32'h1c2d;
      void'($urandom(seed));
      cur_tag = "R1";
      tick(); tick();
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) tick();          // R1 count from zero
      cur_tag = "R3";
      idle(40);                                     // R3 free run
      cur_tag = "R4";
      idle(3);
      mark(1'b1, 1'b0, 1); idle(20);                // R4 single mark, positive rail
      cur_tag = "R2";
      mark(1'b0, 1'b1, 1); idle(13);                // R2 negative rail
      mark(1'b1, 1'b1, 2); idle(17);                // R2 both rails
      cur_tag = "R5";
      mark(1'b1, 1'b0, 35); idle(10);               // R5 held activity
      cur_tag = "R4";
      for (int m = 0; m < 40; m++) begin            // R4 jittered mark train
         mark(1'b1, 1'b0, 1);
         idle(6 + int'($urandom_range(0, 2)));
      end
      cur_tag = "R6";
      for (int i = 0; i < 3000; i++) begin          // R6/R7 random mix
         int r;
         r = int'($urandom_range(0, 99));
         rx_pos = (r < 15);
         rx_neg = (r >= 85);
         ext_clk_in = 1'($urandom_range(0, 1));
         if ($urandom_range(0, 199) == 0) mode_int = ~mode_int;
         tick();
      end
      mode_int = 1'b0;                               // R7 directed
      for (int i = 0; i < 8; i++) begin
         rx_pos = i[0]; rx_neg = i[1]; ext_clk_in = i[2];
         tick();
      end
      mode_int = 1'b1;
      idle(4);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk_ref);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule